// File: doc/BRIEF.md
# Time-of-Day Register Front End

This block is the 32-bit memory-mapped register face of a time-of-day counter. Software uses a simple strobe bus to reach it. A read of the nanosecond word captures the whole running time in one cycle, so the two seconds words read after it always belong to the same instant. A write goes the other way. The two seconds words are parked in holding registers, and the new time reaches the counter only when the nanosecond word is written. Software must therefore read the nanosecond word first and write it last.

The block also holds the counter's rate controls: the nominal period, the temporary adjust period and its cycle count, and the drift correction value and rate. It reports the adjust countdown live from the counter, and it exposes a read-only register that gives the counter clock rate in Hz. The counter itself is outside this block.

A small state machine records what the previous bus cycle asked for. ST_IDLE means nothing is pending. ST_READ_RESP means a read response is on the bus. ST_TIME_COMMIT means the new time is being offered to the counter. ST_ADJ_START means a new adjust count is being offered. Every cycle the next state follows from the current request alone. A read goes to ST_READ_RESP, a nanosecond write goes to ST_TIME_COMMIT, an adjust-count write goes to ST_ADJ_START, and anything else, including no request, goes to ST_IDLE. This holds from every state.

Top module: `tod_regif`

## Requirements
- R1: After reset, rsp_valid, load_o and adj_start_o are low, period_o equals RST_PERIOD (default 0x40000), and the adjust period, adjust count, drift value and drift rate outputs are zero.
- R2: Every read request (req_valid high, req_write low) is answered with rsp_valid high for exactly the following cycle, with the data registered in rsp_rdata. rsp_valid is low in every other cycle.
- R3: A read of byte offset 0x108 returns the live nanosecond input. In the same cycle it captures the live 48-bit seconds input into a snapshot.
- R4: A read of offset 0x104 returns snapshot seconds bits [31:0]. A read of offset 0x100 returns snapshot seconds bits [47:32] in data bits [15:0], with zeros above. The snapshot changes only on a read of 0x108.
- R5: A write to 0x100 stores data bits [15:0] as pending seconds bits [47:32]. A write to 0x104 stores pending seconds bits [31:0]. Neither write raises load_o, and neither changes what 0x100 or 0x104 read back.
- R6: A write to 0x108 raises load_o for exactly one cycle, in the cycle after the write. During that cycle load_sec_o carries the pending seconds and load_ns_o carries the written word.
- R7: Offsets 0x110 (period) and 0x114 (adjust period) each keep data bits [19:0], ignore the higher bits and read back zero-extended.
- R8: Offsets 0x11C (drift value) and 0x120 (drift rate) each keep data bits [15:0] and read back zero-extended.
- R9: A write to 0x118 stores data bits [19:0] on adj_count_o and raises adj_start_o for exactly the next cycle. A read of 0x118 returns the live adj_remain_i input.
- R10: Offset 0x038 reads back CLK_FREQ_HZ, and writes to it change nothing.
- R11: Any offset not listed reads as zero, and writes to it change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Registered read data |
| live_sec_i | input | 48 | Running seconds from the counter |
| live_ns_i | input | 32 | Running nanoseconds from the counter |
| load_o | output | 1 | One-cycle strobe to load a new time |
| load_sec_o | output | 48 | Seconds to load |
| load_ns_o | output | 32 | Nanoseconds to load |
| period_o | output | 20 | Nominal period per clock, 16-bit fraction |
| adj_period_o | output | 20 | Period used while an adjustment runs |
| adj_count_o | output | 20 | Cycles to apply the adjust period |
| adj_start_o | output | 1 | One-cycle strobe to start an adjustment |
| adj_remain_i | input | 20 | Live remaining adjust cycles |
| drift_value_o | output | 16 | Drift correction amount |
| drift_rate_o | output | 16 | Cycles between drift corrections |

## Verification
Assertions check the following on every cycle:
- the one-cycle read handshake;
- load and adjust strobes that appear only after the matching write;
- seconds writes that never raise a load;
- snapshot, holding and control registers that stay unchanged between their own writes.

Only the bench's scenarios can show the data itself. That covers read values taken from the snapshot rather than the live time after the inputs move, the masking of upper data bits, the pending seconds assembled across three writes, and reads of the frequency register and of undecoded offsets.

// File: rtl/tod_regif_pkg.sv
package tod_regif_pkg;

    localparam int ADDR_W = 12;

    // Byte offsets; software depends on these positions
    localparam logic [ADDR_W-1:0] OFS_CLK_RATE   = 12'h038;
    localparam logic [ADDR_W-1:0] OFS_SEC_HI     = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_SEC_LO     = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_NSEC       = 12'h108;
    localparam logic [ADDR_W-1:0] OFS_PERIOD     = 12'h110;
    localparam logic [ADDR_W-1:0] OFS_ADJ_PERIOD = 12'h114;
    localparam logic [ADDR_W-1:0] OFS_ADJ_COUNT  = 12'h118;
    localparam logic [ADDR_W-1:0] OFS_DRIFT_VAL  = 12'h11C;
    localparam logic [ADDR_W-1:0] OFS_DRIFT_RATE = 12'h120;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_READ_RESP   = 2'd1,
        ST_TIME_COMMIT = 2'd2,
        ST_ADJ_START   = 2'd3
    } bus_state_e;

endpackage

// File: rtl/tod_time_snapshot.sv
module tod_time_snapshot #(
    parameter int SEC_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [SEC_W-1:0] live_sec,
    output logic [SEC_W-1:0] snap_sec
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_sec <= '0;
        end else if (capture) begin
            snap_sec <= live_sec;
        end
    end

    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(snap_sec)); // R4

endmodule

// File: rtl/tod_time_stage.sv
module tod_time_stage #(
    parameter int SEC_W = 48,
    parameter int NS_W  = 32,
    parameter int LO_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic             wr_ns,
    input  logic [SEC_W-LO_W-1:0] hi_data,
    input  logic [LO_W-1:0]  lo_data,
    input  logic [NS_W-1:0]  ns_data,
    output logic [SEC_W-1:0] stage_sec,
    output logic [NS_W-1:0]  stage_ns
);

    localparam int HI_W = SEC_W - LO_W;

    logic [HI_W-1:0] hold_hi;
    logic [LO_W-1:0] hold_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_hi  <= '0;
            hold_lo  <= '0;
            stage_ns <= '0;
        end else begin
            if (wr_hi) hold_hi  <= hi_data;
            if (wr_lo) hold_lo  <= lo_data;
            if (wr_ns) stage_ns <= ns_data;
        end
    end

    assign stage_sec = {hold_hi, hold_lo};

    AST_STAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hi && !wr_lo) |=> $stable(stage_sec)); // R5

    AST_STAGE_NS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ns |=> $stable(stage_ns)); // R6

endmodule

// File: rtl/tod_ctrl_bank.sv
module tod_ctrl_bank #(
    parameter int                PERIOD_W   = 20,
    parameter int                COUNT_W    = 20,
    parameter int                DRIFT_W    = 16,
    parameter logic [PERIOD_W-1:0] RST_PERIOD = 20'h40000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_period,
    input  logic                we_adj_period,
    input  logic                we_adj_count,
    input  logic                we_drift_val,
    input  logic                we_drift_rate,
    input  logic [PERIOD_W-1:0] period_data,
    input  logic [COUNT_W-1:0]  count_data,
    input  logic [DRIFT_W-1:0]  drift_data,
    output logic [PERIOD_W-1:0] period,
    output logic [PERIOD_W-1:0] adj_period,
    output logic [COUNT_W-1:0]  adj_count,
    output logic [DRIFT_W-1:0]  drift_val,
    output logic [DRIFT_W-1:0]  drift_rate
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period     <= RST_PERIOD;
            adj_period <= '0;
            adj_count  <= '0;
            drift_val  <= '0;
            drift_rate <= '0;
        end else begin
            if (we_period)     period     <= period_data;
            if (we_adj_period) adj_period <= period_data;
            if (we_adj_count)  adj_count  <= count_data;
            if (we_drift_val)  drift_val  <= drift_data;
            if (we_drift_rate) drift_rate <= drift_data;
        end
    end

    AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_period && !we_adj_period) |=> ($stable(period) && $stable(adj_period))); // R7

    AST_DRIFT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_drift_val && !we_drift_rate) |=> ($stable(drift_val) && $stable(drift_rate))); // R8

    AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_adj_count |=> $stable(adj_count)); // R9

endmodule

// File: rtl/tod_regif.sv
module tod_regif
    import tod_regif_pkg::*;
#(
    parameter int          DATA_W      = 32,
    parameter int          SEC_W       = 48,
    parameter int          PERIOD_W    = 20,
    parameter int          COUNT_W     = 20,
    parameter int          DRIFT_W     = 16,
    parameter int unsigned CLK_FREQ_HZ = 250_000_000,
    parameter logic [19:0] RST_PERIOD  = 20'h40000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [11:0]         req_addr,
    input  logic [31:0]         req_wdata,
    output logic                rsp_valid,
    output logic [31:0]         rsp_rdata,
    input  logic [47:0]         live_sec_i,
    input  logic [31:0]         live_ns_i,
    output logic                load_o,
    output logic [47:0]         load_sec_o,
    output logic [31:0]         load_ns_o,
    output logic [19:0]         period_o,
    output logic [19:0]         adj_period_o,
    output logic [19:0]         adj_count_o,
    output logic                adj_start_o,
    input  logic [19:0]         adj_remain_i,
    output logic [15:0]         drift_value_o,
    output logic [15:0]         drift_rate_o
);

    localparam int HI_W    = SEC_W - DATA_W;
    localparam int PAD_HI  = DATA_W - HI_W;
    localparam int PAD_PER = DATA_W - PERIOD_W;
    localparam int PAD_CNT = DATA_W - COUNT_W;
    localparam int PAD_DR  = DATA_W - DRIFT_W;

    // ---------------- request decode ----------------
    logic rd_req, wr_req;
    logic hit_sec_hi, hit_sec_lo, hit_nsec, hit_period, hit_adj_period;
    logic hit_adj_count, hit_drift_val, hit_drift_rate, hit_clk_rate;

    assign rd_req = req_valid && !req_write;
    assign wr_req = req_valid &&  req_write;

    assign hit_clk_rate   = (req_addr == OFS_CLK_RATE);
    assign hit_sec_hi     = (req_addr == OFS_SEC_HI);
    assign hit_sec_lo     = (req_addr == OFS_SEC_LO);
    assign hit_nsec       = (req_addr == OFS_NSEC);
    assign hit_period     = (req_addr == OFS_PERIOD);
    assign hit_adj_period = (req_addr == OFS_ADJ_PERIOD);
    assign hit_adj_count  = (req_addr == OFS_ADJ_COUNT);
    assign hit_drift_val  = (req_addr == OFS_DRIFT_VAL);
    assign hit_drift_rate = (req_addr == OFS_DRIFT_RATE);

    // ---------------- sub-blocks ----------------
    logic [SEC_W-1:0] snap_sec;

    tod_time_snapshot #(.SEC_W(SEC_W)) u_snapshot (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (rd_req && hit_nsec),
        .live_sec (live_sec_i),
        .snap_sec (snap_sec)
    );

    tod_time_stage #(.SEC_W(SEC_W), .NS_W(DATA_W), .LO_W(DATA_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hi     (wr_req && hit_sec_hi),
        .wr_lo     (wr_req && hit_sec_lo),
        .wr_ns     (wr_req && hit_nsec),
        .hi_data   (req_wdata[HI_W-1:0]),
        .lo_data   (req_wdata),
        .ns_data   (req_wdata),
        .stage_sec (load_sec_o),
        .stage_ns  (load_ns_o)
    );

    tod_ctrl_bank #(
        .PERIOD_W   (PERIOD_W),
        .COUNT_W    (COUNT_W),
        .DRIFT_W    (DRIFT_W),
        .RST_PERIOD (RST_PERIOD)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .we_period     (wr_req && hit_period),
        .we_adj_period (wr_req && hit_adj_period),
        .we_adj_count  (wr_req && hit_adj_count),
        .we_drift_val  (wr_req && hit_drift_val),
        .we_drift_rate (wr_req && hit_drift_rate),
        .period_data   (req_wdata[PERIOD_W-1:0]),
        .count_data    (req_wdata[COUNT_W-1:0]),
        .drift_data    (req_wdata[DRIFT_W-1:0]),
        .period        (period_o),
        .adj_period    (adj_period_o),
        .adj_count     (adj_count_o),
        .drift_val     (drift_value_o),
        .drift_rate    (drift_rate_o)
    );

    // ---------------- state machine ----------------
    bus_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        if (rd_req)                       state_d = ST_READ_RESP;
        else if (wr_req && hit_nsec)      state_d = ST_TIME_COMMIT;
        else if (wr_req && hit_adj_count) state_d = ST_ADJ_START;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rsp_valid   = 1'b0;
        load_o      = 1'b0;
        adj_start_o = 1'b0;
        unique case (state_q)
            ST_IDLE:        ;
            ST_READ_RESP:   rsp_valid   = 1'b1;
            ST_TIME_COMMIT: load_o      = 1'b1;
            ST_ADJ_START:   adj_start_o = 1'b1;
        endcase
    end

    // ---------------- read data ----------------
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (hit_clk_rate)   rd_mux = DATA_W'(CLK_FREQ_HZ);
        if (hit_sec_hi)     rd_mux = {{PAD_HI{1'b0}}, snap_sec[SEC_W-1:DATA_W]};
        if (hit_sec_lo)     rd_mux = snap_sec[DATA_W-1:0];
        if (hit_nsec)       rd_mux = live_ns_i;
        if (hit_period)     rd_mux = {{PAD_PER{1'b0}}, period_o};
        if (hit_adj_period) rd_mux = {{PAD_PER{1'b0}}, adj_period_o};
        if (hit_adj_count)  rd_mux = {{PAD_CNT{1'b0}}, adj_remain_i};
        if (hit_drift_val)  rd_mux = {{PAD_DR{1'b0}}, drift_value_o};
        if (hit_drift_rate) rd_mux = {{PAD_DR{1'b0}}, drift_rate_o};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rsp_rdata <= '0;
        else if (rd_req) rsp_rdata <= rd_mux;
    end

    // ---------------- assertions ----------------
    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R2

    AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write)); // R2

    AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> $past(req_valid && req_write && req_addr == OFS_NSEC)); // R6

    AST_SEC_WRITE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (req_addr == OFS_SEC_HI || req_addr == OFS_SEC_LO)) |=> !load_o); // R5

    AST_ADJ_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        adj_start_o |-> $past(req_valid && req_write && req_addr == OFS_ADJ_COUNT)); // R9

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, load_o, adj_start_o})); // R2

endmodule

// File: tb/tod_regif_tb.sv
`timescale 1ns/1ps
module tod_regif_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [47:0] live_sec_i = '0;
    logic [31:0] live_ns_i = '0;
    logic        load_o;
    logic [47:0] load_sec_o;
    logic [31:0] load_ns_o;
    logic [19:0] period_o, adj_period_o, adj_count_o;
    logic        adj_start_o;
    logic [19:0] adj_remain_i = '0;
    logic [15:0] drift_value_o, drift_rate_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tod_regif u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .live_sec_i(live_sec_i), .live_ns_i(live_ns_i),
        .load_o(load_o), .load_sec_o(load_sec_o), .load_ns_o(load_ns_o),
        .period_o(period_o), .adj_period_o(adj_period_o), .adj_count_o(adj_count_o),
        .adj_start_o(adj_start_o), .adj_remain_i(adj_remain_i),
        .drift_value_o(drift_value_o), .drift_rate_o(drift_rate_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        v = rsp_valid;
        d = rsp_rdata;
    endtask

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;   // write data, or expected read data
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 12'h110, 32'hFFFF_FFFF},  // R7 period masked
        '{1'b0, 12'h110, 32'h000F_FFFF},
        '{1'b1, 12'h114, 32'hF001_2345},  // R7 adjust period
        '{1'b0, 12'h114, 32'h0001_2345},
        '{1'b1, 12'h11C, 32'hABCD_1234},  // R8 drift value
        '{1'b0, 12'h11C, 32'h0000_1234},
        '{1'b1, 12'h120, 32'h5555_00FF},  // R8 drift rate
        '{1'b0, 12'h120, 32'h0000_00FF},
        '{1'b0, 12'h038, 32'h0EE6_B280},  // R10 clock rate
        '{1'b1, 12'h038, 32'h0000_0005},
        '{1'b0, 12'h038, 32'h0EE6_B280},
        '{1'b0, 12'h10C, 32'h0000_0000},  // R11 undecoded
        '{1'b1, 12'h10C, 32'hDEAD_BEEF},
        '{1'b0, 12'h10C, 32'h0000_0000},
        '{1'b1, 12'h124, 32'h1234_5678},  // R11 next to decoded range
        '{1'b0, 12'h110, 32'h000F_FFFF}   // R11 period untouched
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic v;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 load_o", 64'(load_o), 64'd0);
        chk("R1 adj_start_o", 64'(adj_start_o), 64'd0);
        chk("R1 period_o", 64'(period_o), 64'h40000);
        chk("R1 ctrl zero", 64'({adj_period_o, adj_count_o, drift_value_o, drift_rate_o}), 64'd0);

        // Table walk: R7 R8 R10 R11
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].wr) begin
                bus_write(VECS[i].addr, VECS[i].data);
                chk("R11 no strobe after plain write", 64'({load_o, adj_start_o}), 64'd0);
            end else begin
                bus_read(VECS[i].addr, d, v);
                chk($sformatf("R2 valid vec %0d", i), 64'(v), 64'd1);
                chk($sformatf("R7/R8/R10/R11 data vec %0d", i), 64'(d), 64'(VECS[i].data));
            end
        end
        chk("R11 drift untouched", 64'({drift_value_o, drift_rate_o}), 64'h1234_00FF);

        // R2 valid lasts exactly one cycle
        bus_read(12'h110, d, v);
        @(negedge clk);
        chk("R2 valid drops", 64'(rsp_valid), 64'd0);

        // R3 / R4 snapshot
        live_sec_i = 48'h1234_89AB_CDEF; live_ns_i = 32'd999;
        bus_read(12'h108, d, v);
        chk("R3 ns live", 64'(d), 64'd999);
        live_sec_i = 48'hAAAA_0000_0001; live_ns_i = 32'd5;
        bus_read(12'h104, d, v);
        chk("R4 sec lo snapshot", 64'(d), 64'h89AB_CDEF);
        bus_read(12'h100, d, v);
        chk("R4 sec hi snapshot", 64'(d), 64'h0000_1234);
        bus_read(12'h108, d, v);
        chk("R3 ns live again", 64'(d), 64'd5);
        bus_read(12'h100, d, v);
        chk("R3 sec hi recaptured", 64'(d), 64'h0000_AAAA);

        // R5 / R6 staged write
        bus_write(12'h100, 32'hFFFF_0055);
        chk("R5 no load after hi", 64'(load_o), 64'd0);
        bus_write(12'h104, 32'h1122_3344);
        chk("R5 no load after lo", 64'(load_o), 64'd0);
        bus_read(12'h104, d, v);
        chk("R5 lo readback is snapshot", 64'(d), 64'h0000_0001);
        bus_write(12'h108, 32'h3B9A_C9FF);
        chk("R6 load pulse", 64'(load_o), 64'd1);
        chk("R6 load sec", 64'(load_sec_o), 64'h0055_1122_3344);
        chk("R6 load ns", 64'(load_ns_o), 64'h3B9A_C9FF);
        @(negedge clk);
        chk("R6 load one cycle", 64'(load_o), 64'd0);

        // R9 adjust count
        adj_remain_i = 20'd7;
        bus_write(12'h118, 32'h0010_0003);
        chk("R9 start pulse", 64'(adj_start_o), 64'd1);
        chk("R9 count masked", 64'(adj_count_o), 64'd3);
        @(negedge clk);
        chk("R9 start one cycle", 64'(adj_start_o), 64'd0);
        bus_read(12'h118, d, v);
        chk("R9 live remain", 64'(d), 64'd7);
        adj_remain_i = 20'd0;
        bus_read(12'h118, d, v);
        chk("R9 remain zero", 64'(d), 64'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule